// File: doc/BRIEF.md
# Block-refill memory bus sequencer

This block sits on the memory-bus side of a cache refill path. A cache hands it a word address. The sequencer refills the whole block containing that word over a bus that is one word wide, from a memory whose access latency is fixed. The block address is aligned down to a block boundary. After acceptance the sequencer spends one bus cycle presenting the block address. It then moves the block one word at a time, in ascending order. For each word it waits out the memory access time and then spends the transfer time taking that word from the bus.

Every delivered word is marked with a strobe and its index within the block, and the cache captures it from the delivery outputs. A done pulse marks the last word. The number of busy cycles is fixed exactly at one address cycle plus, for each word, the access cycles and the transfer cycles. With the default settings (4 words, 15 access cycles, 1 transfer cycle) a refill lasts 65 bus cycles. A running cycle count is brought out so that this budget can be observed. The sequencer takes one refill at a time, and its ready output holds off the requester while a refill is in progress.

Top module: `blkfill_seq`

## Requirements
- R1: While idle, `req_ready` is 1 and a request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The block base is `req_addr` with its low log2(WORDS) bits cleared. WORDS must be a power of two.
- R2: The first busy cycle after acceptance is the address cycle. In it `bus_addr_strobe` is 1, `bus_addr` equals the block base and `req_ready` is 0. `bus_addr_strobe` is 0 in every other cycle.
- R3: For word i, the address cycle is followed by LAT_CYC access cycles and then XFER_CYC transfer cycles. Throughout these cycles `bus_addr` carries base + i.
- R4: `fill_valid` is 1 for exactly one cycle per word: the last transfer cycle of that word. In that cycle `fill_data` equals `bus_rdata`.
- R5: Words are delivered in ascending order. `fill_idx` reads 0, 1, ... WORDS-1 on the successive `fill_valid` cycles.
- R6: `refill_done` is 1 only in the cycle of the last word's `fill_valid`. A refill occupies exactly 1 + WORDS*(LAT_CYC+XFER_CYC) busy cycles, which is 65 for the defaults. `req_ready` returns to 1 in the cycle after `refill_done`.
- R7: `req_valid` and `req_addr` are ignored while busy, and the refill in progress is unchanged. A request held through `refill_done` is accepted on the first idle edge that follows.
- R8: `cycle_cnt` is 0 while idle and reads k in the k-th busy cycle, so it equals the full budget in the `refill_done` cycle.
- R9: `rst_n` is asynchronous and active low. In reset the block is idle: `req_ready` is 1, all strobes are 0 and `cycle_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Refill request |
| req_addr | input | ADDR_W | Word address inside the wanted block |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| bus_addr_strobe | output | 1 | Address cycle marker |
| bus_addr | output | ADDR_W | Block base in the address cycle, current word address afterwards |
| bus_rdata | input | DATA_W | Word returned by memory |
| fill_valid | output | 1 | Word delivered this cycle |
| fill_idx | output | IDX_W | Index of the delivered word in the block |
| fill_data | output | DATA_W | Delivered word |
| refill_done | output | 1 | Last word delivered this cycle |
| cycle_cnt | output | CYC_W | Busy-cycle count of the current refill |

## Verification
A phase timer that is off by one cycle moves `fill_valid` away from the predicted cycle. It also changes `cycle_cnt` at `refill_done`, so the per-cycle comparison catches it on the first word, LAT_CYC+XFER_CYC+1 cycles after acceptance. A wrong word index or a wrong base shows up on `bus_addr` during the same access window, before the word is even delivered. A wrong idle or busy state shows up as `req_ready` being wrong, or as a held request being taken at the wrong edge, in the cycle right after acceptance or right after done. The bench runs three parameter settings so that each of these faults is seen under more than one timing budget.

// File: rtl/blkfill_pkg.sv
package blkfill_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_ACCESS = 2'd2,
    PH_XFER   = 2'd3
  } phase_t;

  // Busy cycles of one refill: address cycle plus access and transfer per word.
  function automatic int refill_cycles(input int words, input int lat, input int xfer);
    return 1 + words * (lat + xfer);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/blkfill_phase_timer.sv
module blkfill_phase_timer #(
  parameter int LAT_CYC  = 15,
  parameter int XFER_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_access,
  input  logic load_xfer,
  output logic expired
);
  localparam int TW = $clog2(blkfill_pkg::max2(LAT_CYC, XFER_CYC) + 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain <= '0;
    else if (load_access)
      remain <= TW'(LAT_CYC - 1);
    else if (load_xfer)
      remain <= TW'(XFER_CYC - 1);
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

  initial begin
    assert (LAT_CYC >= 1 && XFER_CYC >= 1)
      else $error("phase timer needs at least one cycle per phase");
  end
endmodule

// File: rtl/blkfill_word_ctr.sv
module blkfill_word_ctr #(
  parameter int WORDS = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx <= '0;
    else if (clear)
      idx <= '0;
    else if (step && !last)
      idx <= idx + 1'b1;
  end

  assign last = (idx == IDX_W'(WORDS - 1));
endmodule

// File: rtl/blkfill_ctrl.sv
module blkfill_ctrl
  import blkfill_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   tmr_expired,
  input  logic   last_word,
  output phase_t phase,
  output logic   accept,
  output logic   load_access,
  output logic   load_xfer,
  output logic   word_step,
  output logic   done
);
  phase_t phase_nx;

  always_comb begin
    phase_nx    = phase;
    accept      = 1'b0;
    load_access = 1'b0;
    load_xfer   = 1'b0;
    word_step   = 1'b0;
    done        = 1'b0;
    unique case (phase)
      PH_IDLE: if (req_valid) begin
        accept   = 1'b1;
        phase_nx = PH_ADDR;
      end
      PH_ADDR: begin
        load_access = 1'b1;
        phase_nx    = PH_ACCESS;
      end
      PH_ACCESS: if (tmr_expired) begin
        load_xfer = 1'b1;
        phase_nx  = PH_XFER;
      end
      PH_XFER: if (tmr_expired) begin
        word_step = 1'b1;
        if (last_word) begin
          done     = 1'b1;
          phase_nx = PH_IDLE;
        end else begin
          load_access = 1'b1;
          phase_nx    = PH_ACCESS;
        end
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/blkfill_seq.sv
module blkfill_seq
  import blkfill_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int WORDS    = 4,
  parameter int LAT_CYC  = 15,
  parameter int XFER_CYC = 1,
  localparam int IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int TOTAL   = refill_cycles(WORDS, LAT_CYC, XFER_CYC),
  localparam int CYC_W   = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              bus_addr_strobe,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              fill_valid,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [DATA_W-1:0] fill_data,
  output logic              refill_done,
  output logic [CYC_W-1:0]  cycle_cnt
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORDS - 1);

  // Named internal events
  phase_t            phase;
  logic              ev_accept;
  logic              ev_load_access;
  logic              ev_load_xfer;
  logic              ev_word_step;
  logic              ev_done;
  logic              tmr_expired;
  logic              last_word;
  logic [IDX_W-1:0]  word_idx;
  logic [ADDR_W-1:0] base_q;

  blkfill_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .tmr_expired (tmr_expired),
    .last_word   (last_word),
    .phase       (phase),
    .accept      (ev_accept),
    .load_access (ev_load_access),
    .load_xfer   (ev_load_xfer),
    .word_step   (ev_word_step),
    .done        (ev_done)
  );

  blkfill_phase_timer #(
    .LAT_CYC  (LAT_CYC),
    .XFER_CYC (XFER_CYC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_access (ev_load_access),
    .load_xfer   (ev_load_xfer),
    .expired     (tmr_expired)
  );

  blkfill_word_ctr #(
    .WORDS (WORDS)
  ) u_words (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ev_accept),
    .step  (ev_word_step),
    .idx   (word_idx),
    .last  (last_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         base_q <= '0;
    else if (ev_accept) base_q <= req_addr & ALIGN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cycle_cnt <= '0;
    else if (ev_accept)          cycle_cnt <= CYC_W'(1);
    else if (ev_done)            cycle_cnt <= '0;
    else if (phase != PH_IDLE)   cycle_cnt <= cycle_cnt + 1'b1;
  end

  assign req_ready       = (phase == PH_IDLE);
  assign bus_addr_strobe = (phase == PH_ADDR);
  assign bus_addr        = bus_addr_strobe ? base_q : (base_q | ADDR_W'(word_idx));
  assign fill_valid      = (phase == PH_XFER) && tmr_expired;
  assign fill_idx        = word_idx;
  assign fill_data       = bus_rdata;
  assign refill_done     = ev_done;

  // Assertions
  assert_addr_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_addr_strobe && !req_ready));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !bus_addr_strobe && !fill_valid) |=> $stable(bus_addr));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_addr_strobe, fill_valid}));

  assert_idx_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !refill_done) |=> (fill_idx == $past(fill_idx) + 1'b1));

  assert_done_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |-> (fill_valid && fill_idx == IDX_W'(WORDS - 1)));

  assert_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |-> (cycle_cnt == CYC_W'(TOTAL)));

  assert_ready_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |=> req_ready);

  assert_idle_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cycle_cnt == '0));

  initial begin
    assert ((WORDS & (WORDS - 1)) == 0 && WORDS >= 1)
      else $error("WORDS must be a power of two");
  end
endmodule

// File: tb/blkfill_seq_bench.sv
module blkfill_seq_harness #(
  parameter int    WORDS    = 4,
  parameter int    LAT_CYC  = 15,
  parameter int    XFER_CYC = 1,
  parameter string TAG      = "cfg"
) (
  input  logic clk,
  input  logic rst_n,
  output logic finished
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int TOTAL = 1 + WORDS * (LAT_CYC + XFER_CYC);
  localparam int CYC_W = $clog2(TOTAL + 1);

  logic              req_valid;
  logic [15:0]       req_addr;
  logic              req_ready;
  logic              bus_addr_strobe;
  logic [15:0]       bus_addr;
  logic [31:0]       bus_rdata;
  logic              fill_valid;
  logic [IDX_W-1:0]  fill_idx;
  logic [31:0]       fill_data;
  logic              refill_done;
  logic [CYC_W-1:0]  cycle_cnt;

  integer n_vec  = 0;
  integer n_miss = 0;

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  assign bus_rdata = mem_word(bus_addr);

  blkfill_seq #(
    .ADDR_W (16), .DATA_W (32), .WORDS (WORDS),
    .LAT_CYC (LAT_CYC), .XFER_CYC (XFER_CYC)
  ) u_blkfill_seq (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_addr (req_addr), .req_ready (req_ready),
    .bus_addr_strobe (bus_addr_strobe), .bus_addr (bus_addr), .bus_rdata (bus_rdata),
    .fill_valid (fill_valid), .fill_idx (fill_idx), .fill_data (fill_data),
    .refill_done (refill_done), .cycle_cnt (cycle_cnt)
  );

  // Reference model: t = 0 idle, else index of the current busy cycle.
  integer m_t    = 0;
  integer m_base = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_t <= 0;
    else if (m_t == 0 && req_valid) begin
      m_t    <= 1;
      m_base <= (int'(req_addr) / WORDS) * WORDS;
    end else if (m_t == TOTAL) m_t <= 0;
    else if (m_t != 0) m_t <= m_t + 1;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec = n_vec + 1;
    if (act !== exp) begin
      n_miss = n_miss + 1;
      $display("FAIL %s %s %s: actual %0h expected %0h at %0t", TAG, req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int k, i, ph;
    logic e_valid, e_done;
    string r_rdy, r_str, r_adr, r_val, r_idx, r_dat, r_don, r_cnt;
    if (!rst_n) begin
      r_rdy = "R9"; r_str = "R9"; r_adr = "R9"; r_val = "R9";
      r_idx = "R9"; r_dat = "R9"; r_don = "R9"; r_cnt = "R9";
    end else begin
      r_rdy = "R1/R7"; r_str = "R2"; r_adr = "R3"; r_val = "R4";
      r_idx = "R5"; r_dat = "R4"; r_don = "R6"; r_cnt = "R8";
    end
    e_valid = 1'b0; e_done = 1'b0; i = 0;
    if (m_t == 0) begin
      chk(r_rdy, "req_ready", 64'(req_ready), 64'd1);
      chk(r_str, "bus_addr_strobe", 64'(bus_addr_strobe), 64'd0);
      chk(r_cnt, "cycle_cnt", 64'(cycle_cnt), 64'd0);
    end else begin
      chk(r_rdy, "req_ready", 64'(req_ready), 64'd0);
      chk(r_str, "bus_addr_strobe", 64'(bus_addr_strobe), 64'(m_t == 1));
      chk(r_cnt, "cycle_cnt", 64'(cycle_cnt), 64'(m_t));
      if (m_t == 1) chk("R2", "bus_addr", 64'(bus_addr), 64'(m_base));
      else begin
        k  = m_t - 2;
        i  = k / (LAT_CYC + XFER_CYC);
        ph = k % (LAT_CYC + XFER_CYC);
        chk(r_adr, "bus_addr", 64'(bus_addr), 64'(m_base + i));
        e_valid = (ph == LAT_CYC + XFER_CYC - 1);
        e_done  = e_valid && (i == WORDS - 1);
      end
    end
    chk(r_val, "fill_valid", 64'(fill_valid), 64'(e_valid));
    chk(r_don, "refill_done", 64'(refill_done), 64'(e_done));
    if (e_valid) begin
      chk(r_idx, "fill_idx", 64'(fill_idx), 64'(i));
      chk(r_dat, "fill_data", 64'(fill_data), 64'(mem_word(16'(m_base + i))));
    end
    if (e_done) // R6 budget: 1 + WORDS*(LAT_CYC+XFER_CYC)
      chk("R6", "budget", 64'(cycle_cnt), 64'(1 + WORDS * (LAT_CYC + XFER_CYC)));
  end

  task automatic send(input logic [15:0] a);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_t != 0) @(negedge clk);
  endtask

  initial begin
    req_valid = 1'b0; req_addr = '0; finished = 1'b0;
    @(posedge rst_n);
    repeat (2) @(negedge clk);
    send(16'h1236);              // R1 unaligned address
    wait_idle();
    send(16'hFFFF);              // R1 top of address space
    wait_idle();
    // R7: request held while busy with a changing address
    @(negedge clk); req_valid = 1'b1; req_addr = 16'h0041;
    @(negedge clk); req_addr = 16'h7777;
    while (m_t != 0) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    wait_idle();
    send(16'h0000);              // R1 lowest block, back to back
    send(16'h0BAD);
    wait_idle();
    repeat (3) @(negedge clk);
    finished = 1'b1;
  end
endmodule

module blkfill_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fin_a, fin_b, fin_c;

  always #2 clk = ~clk;   // 250 MHz

  blkfill_seq_harness #(.WORDS(4), .LAT_CYC(15), .XFER_CYC(1), .TAG("w4l15x1"))
    h_a (.clk(clk), .rst_n(rst_n), .finished(fin_a));
  blkfill_seq_harness #(.WORDS(2), .LAT_CYC(3), .XFER_CYC(2), .TAG("w2l3x2"))
    h_b (.clk(clk), .rst_n(rst_n), .finished(fin_b));
  blkfill_seq_harness #(.WORDS(8), .LAT_CYC(1), .XFER_CYC(1), .TAG("w8l1x1"))
    h_c (.clk(clk), .rst_n(rst_n), .finished(fin_c));

  initial begin
    int vec, miss;
    repeat (3) @(negedge clk);   // R9 reset state checked by the harnesses
    rst_n = 1'b1;
    for (int c = 0; c < 20000 && !(fin_a && fin_b && fin_c); c++) @(posedge clk);
    vec  = h_a.n_vec + h_b.n_vec + h_c.n_vec;
    miss = h_a.n_miss + h_b.n_miss + h_c.n_miss;
    if (!(fin_a && fin_b && fin_c)) begin
      vec  = vec + 1;
      miss = miss + 1;
      $display("FAIL watchdog: actual unfinished expected finished");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule